// File: doc/BRIEF.md
# AES Column Mixing Stage

This block performs the column-mixing step of the AES round on a full 128-bit state. The state is split into four columns of four bytes. Each column is multiplied, as a polynomial with GF(2^8) coefficients, by the fixed polynomial 03x^3 + 01x^2 + 01x + 02, reduced modulo x^4 + 1. This is the same as multiplying the column by a circulant matrix whose first row is {02,03,01,01}. Byte addition is XOR. Doubling is a one-bit shift with a conditional reduction. Tripling is a doubled byte XORed with the original byte. No general multiplier is used.

A state is presented with a valid strobe. The mixed state appears on a registered output one clock later, with its own valid flag. The output register holds its contents while no new state is offered. A synchronous reset clears both the flag and the data.

Top module: `aes_mixcol_unit`

## Requirements
- R1: Byte k of a state occupies bits [8k+7:8k], and column c is made of bytes 4c..4c+3, with byte 4c as a0. Each output column is b0=2a0^3a1^a2^a3, b1=a0^2a1^3a2^a3, b2=a0^a1^2a2^3a3, b3=3a0^a1^a2^2a3.
- R2: Multiplication by 2 shifts the byte left one bit. When the input byte's top bit was 1, the result is then XORed with 0x1B.
- R3: Multiplication by 3 equals the doubled byte XORed with the original byte.
- R4: outValid is high in exactly the cycle after a cycle in which inValid was high, and low otherwise.
- R5: A synchronous reset (rst high at a clock edge) drives outValid to 0 and outState to all zeros. This takes priority over inValid.
- R6: While inValid is low, outState keeps its previous value regardless of inState.
- R7: Each output column depends only on the four input bytes of the same column. A change confined to one column leaves the other columns of the result unaffected.
- R8: The input column DB,13,53,45 yields 8E,4D,A1,BC. The column 01,01,01,01 yields itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input state is valid this cycle |
| inState | input | 128 | Input state, column-major, byte 0 in bits 7:0 |
| outValid | output | 1 | outState holds a newly mixed state |
| outState | output | 128 | Registered mixed state |

## Verification
A single nonzero byte is swept through all 256 values in each of the 16 byte positions, with every other byte zero.
- Each sweep isolates one matrix coefficient per output byte. Values at or above 0x80 separate a correct reduction from a plain shift.
- The zero columns around the swept byte expose any leakage between columns.
- The two fixed columns pin the transform against published results.
- Pseudo-random full states exercise all bytes at once.
- Idle cycles with a changing input show whether the output register holds.
- A reset pulse issued together with a valid input shows that reset wins.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;

  localparam int BYTE_W    = 8;
  localparam int COL_BYTES = 4;
  localparam int COL_W     = BYTE_W * COL_BYTES;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureEn;
    logic clearEn;
  } mixcol_strobe_t;

  // Doubling in GF(2^8): shift, then fold the carried-out bit back in
  function automatic logic [BYTE_W-1:0] gfDouble(
    input logic [BYTE_W-1:0] b,
    input logic [BYTE_W-1:0] reducePoly
  );
    logic [BYTE_W-1:0] shifted;
    shifted = {b[BYTE_W-2:0], 1'b0};
    return b[BYTE_W-1] ? (shifted ^ reducePoly) : shifted;
  endfunction

endpackage

// File: rtl/mixcol_column.sv
module mixcol_column
  import mixcol_pkg::*;
#(
  parameter logic [BYTE_W-1:0] REDUCE_POLY = 8'h1B
) (
  input  logic [COL_W-1:0] colIn,
  output logic [COL_W-1:0] colOut
);

  logic [BYTE_W-1:0] aByte [COL_BYTES];
  logic [BYTE_W-1:0] dByte [COL_BYTES];
  logic [BYTE_W-1:0] tByte [COL_BYTES];

  for (genvar i = 0; i < COL_BYTES; i++) begin : g_byte
    assign aByte[i] = colIn[i*BYTE_W +: BYTE_W];
    assign dByte[i] = gfDouble(aByte[i], REDUCE_POLY);
    assign tByte[i] = dByte[i] ^ aByte[i];
  end

  // Circulant row r: 2 on the diagonal, 3 to its right, 1 elsewhere
  for (genvar r = 0; r < COL_BYTES; r++) begin : g_row
    assign colOut[r*BYTE_W +: BYTE_W] = dByte[r]
                                      ^ tByte[(r + 1) % COL_BYTES]
                                      ^ aByte[(r + 2) % COL_BYTES]
                                      ^ aByte[(r + 3) % COL_BYTES];
  end

endmodule

// File: rtl/mixcol_datapath.sv
module mixcol_datapath
  import mixcol_pkg::*;
#(
  parameter int                NUM_COLS    = 4,
  parameter logic [BYTE_W-1:0] REDUCE_POLY = 8'h1B,
  localparam int               STATE_W     = COL_W * NUM_COLS
) (
  input  logic                clk,
  input  mixcol_strobe_t      strobe,
  input  logic [STATE_W-1:0]  inState,
  output logic [STATE_W-1:0]  outState
);

  logic [STATE_W-1:0] mixedState;
  logic [STATE_W-1:0] stateQ;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    mixcol_column #(.REDUCE_POLY(REDUCE_POLY)) i_column (
      .colIn  (inState[c*COL_W +: COL_W]),
      .colOut (mixedState[c*COL_W +: COL_W])
    );
  end

  always_ff @(posedge clk) begin
    if (strobe.clearEn) begin
      stateQ <= '0;
    end else if (strobe.captureEn) begin
      stateQ <= mixedState;
    end
  end

  assign outState = stateQ;

endmodule

// File: rtl/mixcol_ctrl.sv
module mixcol_ctrl
  import mixcol_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  output mixcol_strobe_t strobe,
  output logic           outValid
);

  logic validQ;

  always_comb begin
    strobe.clearEn   = rst;
    strobe.captureEn = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
    end else begin
      validQ <= inValid;
    end
  end

  assign outValid = validQ;

endmodule

// File: rtl/aes_mixcol_unit.sv
module aes_mixcol_unit
  import mixcol_pkg::*;
#(
  parameter int  NUM_COLS = 4,
  localparam int STATE_W  = COL_W * NUM_COLS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [STATE_W-1:0] inState,
  output logic               outValid,
  output logic [STATE_W-1:0] outState
);

  mixcol_strobe_t strobe;

  mixcol_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  mixcol_datapath #(.NUM_COLS(NUM_COLS), .REDUCE_POLY(8'h1B)) i_datapath (
    .clk      (clk),
    .strobe   (strobe),
    .inState  (inState),
    .outState (outState)
  );

endmodule

// File: rtl/mixcol_chk.sv
module mixcol_chk
  import mixcol_pkg::*;
#(
  parameter int  NUM_COLS = 4,
  localparam int STATE_W  = COL_W * NUM_COLS
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [STATE_W-1:0] inState,
  input logic               outValid,
  input logic [STATE_W-1:0] outState
);

  // XOR of the four bytes in each column; the row coefficients XOR to 1,
  // so a correct mix leaves this per-column sum unchanged.
  function automatic logic [BYTE_W*NUM_COLS-1:0] colSum(input logic [STATE_W-1:0] s);
    logic [BYTE_W*NUM_COLS-1:0] acc;
    acc = '0;
    for (int c = 0; c < NUM_COLS; c++) begin
      for (int k = 0; k < COL_BYTES; k++) begin
        acc[c*BYTE_W +: BYTE_W] ^= s[c*COL_W + k*BYTE_W +: BYTE_W];
      end
    end
    return acc;
  endfunction

  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R4
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && outState == '0));

  // R6
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(outState));

  // R1
  col_sum_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> colSum(outState) == colSum($past(inState)));

endmodule

bind aes_mixcol_unit mixcol_chk #(.NUM_COLS(NUM_COLS)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inState  (inState),
  .outValid (outValid),
  .outState (outState)
);

// File: tb/test_aes_mixcol_unit.sv
module test_aes_mixcol_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [127:0] inState = '0;
  logic         outValid;
  logic [127:0] outState;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #2 clk = ~clk;

  aes_mixcol_unit i_aes_mixcol_unit (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inState  (inState),
    .outValid (outValid),
    .outState (outState)
  );

  function automatic int mul2(input int b);
    int t;
    t = b * 2;
    if (t >= 256) t = t ^ 'h11B;
    return t;
  endfunction

  function automatic int mul3(input int b);
    return mul2(b) ^ b;
  endfunction

  function automatic logic [127:0] refMix(input logic [127:0] s);
    logic [127:0] r;
    int a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = int'(s[c*32 +: 8]);
      a1 = int'(s[c*32+8 +: 8]);
      a2 = int'(s[c*32+16 +: 8]);
      a3 = int'(s[c*32+24 +: 8]);
      r[c*32 +: 8]    = 8'(mul2(a0) ^ mul3(a1) ^ a2 ^ a3);
      r[c*32+8 +: 8]  = 8'(a0 ^ mul2(a1) ^ mul3(a2) ^ a3);
      r[c*32+16 +: 8] = 8'(a0 ^ a1 ^ mul2(a2) ^ mul3(a3));
      r[c*32+24 +: 8] = 8'(mul3(a0) ^ a1 ^ a2 ^ mul2(a3));
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  // Present one state, then sample after the capturing edge
  task automatic apply(input logic [127:0] s);
    @(negedge clk);
    inValid = 1'b1;
    inState = s;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  logic [127:0] held;

  initial begin
    repeat (3) @(negedge clk);
    check("R5", {127'd0, outValid}, 128'd0);
    check("R5", outState, 128'd0);
    rst = 1'b0;

    // Known columns
    apply({32'h0, 32'h0, 32'h0101_0101, 32'h4553_13DB});
    check("R8", outState, {32'h0, 32'h0, 32'h0101_0101, 32'hBCA1_4D8E});
    check("R4", {127'd0, outValid}, 128'd1);

    // Single-byte sweeps over every position
    for (int p = 0; p < 16; p++) begin
      for (int v = 0; v < 256; v++) begin
        logic [127:0] s;
        logic [127:0] e;
        s = '0;
        s[p*8 +: 8] = 8'(v);
        e = refMix(s);
        apply(s);
        check(v >= 128 ? "R2" : "R1", outState, e);
        if (p == 0) begin
          // b3 of column 0 is 3*a0 when only a0 is set
          check("R3", {120'd0, outState[31:24]}, {120'd0, 8'(mul2(v) ^ v)});
        end
        // Other columns stay zero
        check("R7", outState & ~({96'd0, 32'hFFFF_FFFF} << ((p / 4) * 32)), 128'd0);
      end
    end

    // Random full states, back-to-back
    for (int n = 0; n < 200; n++) begin
      logic [127:0] s;
      for (int w = 0; w < 4; w++) begin
        nextRand();
        s[w*32 +: 32] = lfsr;
      end
      apply(s);
      check("R1", outState, refMix(s));
    end

    // Hold while idle
    held = outState;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      nextRand();
      inState = {4{lfsr}};
      @(negedge clk);
      check("R6", outState, held);
      check("R4", {127'd0, outValid}, 128'd0);
    end

    // Reset wins over a valid input
    @(negedge clk);
    inValid = 1'b1;
    inState = {128{1'b1}};
    rst = 1'b1;
    @(negedge clk);
    check("R5", outState, 128'd0);
    check("R5", {127'd0, outValid}, 128'd0);
    rst = 1'b0;
    inValid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule